// File: doc/BRIEF.md
# Address-Space-Tagged Associative Translation Cache

This block caches virtual-to-physical page translations for a processor's memory unit. Each lookup presents a virtual address and the current address-space tag. Every stored entry compares its page number and tag against the request at the same moment. On a match the physical frame number is joined to the untouched page offset and returned in the same cycle, together with the entry's permission, dirty and referenced flags. A miss tells the requester to obtain the translation elsewhere, write it in through the fill port, and retry.

Because every entry carries its own address-space tag, translations from several processes can share the cache, and a context switch does not have to empty it. When software does need to invalidate entries, one flush cycle removes either everything or only the entries of a single tag. A fill goes to a free slot when one exists. When the cache is full, the fill replaces the entry that was used least recently, where both hits and fills count as use.

Top module: `tlb_assoc`

## Requirements
- R1: On a hit, `lk_paddr` equals the stored frame number concatenated with `lk_vaddr[11:0]`. The page number is `lk_vaddr[31:12]`. On a miss, `lk_paddr` is zero.
- R2: `lk_hit` is 1 exactly when `lk_valid` is 1 and a live entry matches both the page number and `lk_asid`. An entry with the same page number but a different tag does not hit.
- R3: A fill goes into the lowest-numbered entry that is not live whenever such an entry exists, even if a live entry is the least recently used.
- R4: When all entries are live, a fill evicts the least recently used entry. Use means a hit that updates state, or a fill.
- R5: A fill whose page number and tag already exist overwrites that entry, so at most one entry ever matches a key.
- R6: `lk_seen` and `lk_dirty` show the stored flags before the current access. A hit sets the entry's referenced flag and a write hit sets its dirty flag, both from the next cycle. A fill clears both flags.
- R7: A flush with `flush_all`=1 makes every entry not live in one cycle.
- R8: A flush with `flush_all`=0 removes only the entries whose tag equals `flush_asid` and keeps all others.
- R9: A flush overrides a fill in the same cycle, so the fill is lost. A lookup made in a flush or fill cycle changes no flags and no usage order.
- R10: A synchronous reset makes every entry not live.
- R11: On a hit, `lk_perm` returns the stored permission bits (bit 0 read, bit 1 write, bit 2 execute). On a miss it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store access |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 32 | Physical address |
| lk_perm | output | 3 | Permission bits of the hit entry |
| lk_dirty | output | 1 | Stored dirty flag of the hit entry |
| lk_seen | output | 1 | Stored referenced flag of the hit entry |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number to fill |
| fill_asid | input | 8 | Tag to fill |
| fill_pfn | input | 20 | Frame number to fill |
| fill_perm | input | 3 | Permissions to fill |
| flush_en | input | 1 | Invalidate entries this cycle |
| flush_all | input | 1 | 1: all entries, 0: only tag `flush_asid` |
| flush_asid | input | 8 | Tag selected for a partial flush |

## Verification
The bench fills the cache past capacity after a pattern of hits. The victim it expects is the true least recently used entry, so a design with FIFO or round-robin replacement evicts the wrong translation and a later lookup misses or hits where it should not. It gives the same page number two different tags, which exposes a comparator that ignores the tag. It refills a key that is already present, which would otherwise produce a double match. After a partial flush it leaves the only live entry as the oldest one; a design that does not prefer free slots would overwrite it. It also checks that referenced and dirty flags appear one access late, that a partial flush spares other tags, and that a flush wins over a simultaneous fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int PFN_W     = 20;
    localparam int ASID_W    = 8;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PA_W      = PFN_W + PAGE_BITS;

    // bit 0 read, bit 1 write, bit 2 execute
    typedef logic [2:0] perm_t;

    typedef struct packed {
        logic              live;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        perm_t             perm;
        logic              dirty;
        logic              seen;
    } tlb_entry_t;

    function automatic logic key_eq(tlb_entry_t e, logic [VPN_W-1:0] vpn,
                                    logic [ASID_W-1:0] asid);
        return e.live && (e.vpn == vpn) && (e.asid == asid);
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N    = 4,
    parameter int IW   = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  tlb_entry_t          ents [N],
    input  logic [VPN_W-1:0]    key_vpn,
    input  logic [ASID_W-1:0]   key_asid,
    output logic [N-1:0]        hits,
    output logic [IW-1:0]       idx,
    output logic                any
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = key_eq(ents[g], key_vpn, key_asid);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end

    assign any = |hits;

    // R5: the table never holds two entries with the same key
    assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits));
endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] oldest
);
    logic [IW-1:0] age [N];
    logic [N-1:0]  is_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)           age[i] <= '0;
                else if (age[i] < age[touch_idx])  age[i] <= age[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_old
        assign is_old[g] = (age[g] == IW'(N - 1));
    end

    always_comb begin
        oldest = '0;
        for (int i = 0; i < N; i++) begin
            if (is_old[i]) oldest = IW'(i);
        end
    end

    // R4: the usage order always names exactly one oldest entry
    assert_one_oldest_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(is_old) == 1);
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [2:0]        lk_perm,
    output logic              lk_dirty,
    output logic              lk_seen,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [2:0]        fill_perm,
    input  logic              flush_en,
    input  logic              flush_all,
    input  logic [ASID_W-1:0] flush_asid
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t         ents [ENTRIES];
    logic [ENTRIES-1:0] live_vec;
    logic [ENTRIES-1:0] look_hits, dup_hits;
    logic [IDX_W-1:0]   look_idx, dup_idx, free_idx, old_idx, victim, touch_idx;
    logic               look_any, dup_any, has_free;
    logic               fill_do, upd_do, touch;
    tlb_entry_t         sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_live
        assign live_vec[g] = ents[g].live;
    end

    tlb_cam #(.N(ENTRIES), .IW(IDX_W)) u_look (
        .clk(clk), .rst(rst), .ents(ents),
        .key_vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .key_asid(lk_asid),
        .hits(look_hits), .idx(look_idx), .any(look_any));

    tlb_cam #(.N(ENTRIES), .IW(IDX_W)) u_dup (
        .clk(clk), .rst(rst), .ents(ents),
        .key_vpn(fill_vpn), .key_asid(fill_asid),
        .hits(dup_hits), .idx(dup_idx), .any(dup_any));

    tlb_age #(.N(ENTRIES), .IW(IDX_W)) u_age (
        .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
        .oldest(old_idx));

    // lookup result
    assign lk_hit = lk_valid & look_any;
    assign sel    = ents[look_idx];

    always_comb begin
        lk_paddr = '0;
        lk_perm  = '0;
        lk_dirty = 1'b0;
        lk_seen  = 1'b0;
        if (lk_hit) begin
            lk_paddr = {sel.pfn, lk_vaddr[PAGE_BITS-1:0]};
            lk_perm  = sel.perm;
            lk_dirty = sel.dirty;
            lk_seen  = sel.seen;
        end
    end

    // victim choice: existing key, then lowest free slot, then oldest
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ents[i].live) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim    = dup_any ? dup_idx : (has_free ? free_idx : old_idx);
    assign fill_do   = fill_en & ~flush_en;
    assign upd_do    = lk_hit & ~fill_en & ~flush_en;
    assign touch     = fill_do | upd_do;
    assign touch_idx = fill_do ? victim : look_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else if (flush_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all || ents[i].asid == flush_asid) ents[i].live <= 1'b0;
            end
        end else if (fill_en) begin
            ents[victim] <= '{live: 1'b1, asid: fill_asid, vpn: fill_vpn,
                              pfn: fill_pfn, perm: fill_perm,
                              dirty: 1'b0, seen: 1'b0};
        end else if (upd_do) begin
            ents[look_idx].seen <= 1'b1;
            if (lk_write) ents[look_idx].dirty <= 1'b1;
        end
    end

    // R2: no hit without a request
    assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_valid);

    // R7: flush-all empties the table by the next cycle
    assert_flush_all_R7: assert property (@(posedge clk) disable iff (rst)
        (flush_en && flush_all) |=> (live_vec == '0));

    // R3: a new key into a non-full table adds exactly one live entry
    assert_fill_adds_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush_en && !dup_any && !(&live_vec))
        |=> ($countones(live_vec) == $past($countones(live_vec)) + 1));

    // R10: reset leaves no live entry
    assert_reset_empty_R10: assert property (@(posedge clk)
        rst |=> (live_vec == '0));

    // R8: a partial flush spares entries of other tags
    for (genvar g = 0; g < ENTRIES; g++) begin : g_keep
        assert_keep_other_R8: assert property (@(posedge clk) disable iff (rst)
            (flush_en && !flush_all && ents[g].live && ents[g].asid != flush_asid)
            |=> ents[g].live);
    end
endmodule

// File: tb/sim_tlb_assoc.sv
`timescale 1ns/1ps
module sim_tlb_assoc;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_write;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_perm;
    logic        lk_dirty, lk_seen;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic [19:0] fill_pfn;
    logic [2:0]  fill_perm;
    logic        flush_en, flush_all;
    logic [7:0]  flush_asid;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tlb_assoc u0 (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .lk_dirty(lk_dirty), .lk_seen(lk_seen),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_en(flush_en), .flush_all(flush_all), .flush_asid(flush_asid));

    localparam logic [2:0] RD = 3'd0, WR = 3'd1, FL = 3'd2, FA = 3'd3, FS = 3'd4;
    localparam logic [7:0] A1 = 8'd1, A2 = 8'd2, A3 = 8'd3;

    typedef struct packed {
        logic [2:0]  op;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic [19:0] pfn;   // fill data, or expected frame on a lookup
        logic [2:0]  perm;  // fill data, or expected permissions
        logic        hit;
        logic        seen;
        logic        dirty;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{RD, 20'h10, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd10}, //  0 R10 empty after reset
        '{FL, 20'h10, A1, 20'h100, 3'd3, 1'b0, 1'b0, 1'b0, 4'd3 }, //  1 -> e0
        '{FL, 20'h11, A1, 20'h101, 3'd5, 1'b0, 1'b0, 1'b0, 4'd3 }, //  2 -> e1
        '{FL, 20'h10, A2, 20'h200, 3'd1, 1'b0, 1'b0, 1'b0, 4'd3 }, //  3 -> e2
        '{FL, 20'h12, A1, 20'h102, 3'd7, 1'b0, 1'b0, 1'b0, 4'd3 }, //  4 -> e3
        '{RD, 20'h10, A1, 20'h100, 3'd3, 1'b1, 1'b0, 1'b0, 4'd1 }, //  5 R1 R11
        '{RD, 20'h10, A2, 20'h200, 3'd1, 1'b1, 1'b0, 1'b0, 4'd2 }, //  6 R2 tag separates
        '{WR, 20'h10, A1, 20'h100, 3'd3, 1'b1, 1'b1, 1'b0, 4'd6 }, //  7 R6 seen set
        '{RD, 20'h10, A1, 20'h100, 3'd3, 1'b1, 1'b1, 1'b1, 4'd6 }, //  8 R6 dirty set
        '{FL, 20'h13, A1, 20'h103, 3'd3, 1'b0, 1'b0, 1'b0, 4'd4 }, //  9 evicts 11/A1
        '{RD, 20'h11, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd4 }, // 10 R4 victim gone
        '{RD, 20'h12, A1, 20'h102, 3'd7, 1'b1, 1'b0, 1'b0, 4'd4 }, // 11 R4 kept
        '{FL, 20'h14, A1, 20'h104, 3'd1, 1'b0, 1'b0, 1'b0, 4'd4 }, // 12 evicts 10/A2
        '{RD, 20'h10, A2, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd4 }, // 13 R4 victim gone
        '{RD, 20'h10, A1, 20'h100, 3'd3, 1'b1, 1'b1, 1'b1, 4'd4 }, // 14 R4 kept
        '{FL, 20'h12, A1, 20'h1F2, 3'd6, 1'b0, 1'b0, 1'b0, 4'd5 }, // 15 same key refill
        '{RD, 20'h12, A1, 20'h1F2, 3'd6, 1'b1, 1'b0, 1'b0, 4'd5 }, // 16 R5 new data, flags clear
        '{FL, 20'h20, A2, 20'h220, 3'd5, 1'b0, 1'b0, 1'b0, 4'd4 }, // 17 evicts 13/A1
        '{RD, 20'h13, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd4 }, // 18 R4
        '{FS, 20'h00, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd8 }, // 19 flush tag 1
        '{RD, 20'h14, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd8 }, // 20 R8 removed
        '{FL, 20'h30, A1, 20'h300, 3'd3, 1'b0, 1'b0, 1'b0, 4'd3 }, // 21
        '{FL, 20'h31, A1, 20'h301, 3'd3, 1'b0, 1'b0, 1'b0, 4'd3 }, // 22
        '{FL, 20'h32, A1, 20'h302, 3'd3, 1'b0, 1'b0, 1'b0, 4'd3 }, // 23
        '{FS, 20'h00, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd8 }, // 24 only 20/A2 left, oldest
        '{FL, 20'h40, A1, 20'h400, 3'd2, 1'b0, 1'b0, 1'b0, 4'd3 }, // 25 must use free slot
        '{RD, 20'h20, A2, 20'h220, 3'd5, 1'b1, 1'b0, 1'b0, 4'd3 }, // 26 R3 R8 oldest survives
        '{RD, 20'h40, A1, 20'h400, 3'd2, 1'b1, 1'b0, 1'b0, 4'd3 }, // 27 R3
        '{FA, 20'h00, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7 }, // 28 flush all
        '{RD, 20'h20, A2, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7 }, // 29 R7
        '{RD, 20'h40, A1, 20'h000, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7 }  // 30 R7
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 1'b0; lk_write = 1'b0; lk_vaddr = '0; lk_asid = '0;
        fill_en = 1'b0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0;
        flush_en = 1'b0; flush_all = 1'b0; flush_asid = '0;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL all requirements: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        vec_t        v;
        logic [11:0] off;
        string       tag;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            v   = VECS[i];
            off = 12'((i * 37 + 5) & 12'hFFF);
            tag = $sformatf("R%0d", v.rq);
            @(negedge clk);
            idle();
            case (v.op)
                RD, WR: begin
                    lk_valid = 1'b1;
                    lk_write = (v.op == WR);
                    lk_vaddr = {v.vpn, off};
                    lk_asid  = v.asid;
                end
                FL: begin
                    fill_en = 1'b1; fill_vpn = v.vpn; fill_asid = v.asid;
                    fill_pfn = v.pfn; fill_perm = v.perm;
                end
                FA: begin flush_en = 1'b1; flush_all = 1'b1; end
                default: begin flush_en = 1'b1; flush_asid = v.asid; end
            endcase
            #1;
            if (v.op == RD || v.op == WR) begin
                chk(lk_hit == v.hit, tag, 32'(lk_hit), 32'(v.hit), $sformatf("hit row %0d", i));
                if (v.hit) begin
                    chk(lk_paddr == {v.pfn, off}, "R1", lk_paddr, {v.pfn, off}, "paddr");
                    chk(lk_perm == v.perm, "R11", 32'(lk_perm), 32'(v.perm), "perm");
                    chk(lk_seen == v.seen, "R6", 32'(lk_seen), 32'(v.seen), "seen");
                    chk(lk_dirty == v.dirty, "R6", 32'(lk_dirty), 32'(v.dirty), "dirty");
                end else begin
                    chk(lk_paddr == '0 && lk_perm == '0, "R1", lk_paddr, 32'h0, "miss output");
                end
            end
        end

        // R9: flush wins over a fill in the same cycle
        @(negedge clk);
        idle();
        fill_en = 1'b1; fill_vpn = 20'h50; fill_asid = A3; fill_pfn = 20'h550; fill_perm = 3'd1;
        flush_en = 1'b1; flush_all = 1'b1;
        @(negedge clk);
        idle();
        lk_valid = 1'b1; lk_vaddr = {20'h50, 12'h123}; lk_asid = A3;
        #1 chk(lk_hit == 1'b0, "R9", 32'(lk_hit), 32'h0, "fill under flush");

        // R9: a lookup during a fill cycle leaves the flags alone
        @(negedge clk);
        idle();
        fill_en = 1'b1; fill_vpn = 20'h60; fill_asid = A3; fill_pfn = 20'h660; fill_perm = 3'd7;
        @(negedge clk);
        idle();
        fill_en = 1'b1; fill_vpn = 20'h61; fill_asid = A3; fill_pfn = 20'h661; fill_perm = 3'd7;
        lk_valid = 1'b1; lk_write = 1'b1; lk_vaddr = {20'h60, 12'h0}; lk_asid = A3;
        @(negedge clk);
        idle();
        lk_valid = 1'b1; lk_vaddr = {20'h60, 12'hFFF}; lk_asid = A3;
        #1;
        chk(lk_hit == 1'b1, "R9", 32'(lk_hit), 32'h1, "hit after fill");
        chk(lk_seen == 1'b0 && lk_dirty == 1'b0, "R9", {lk_seen, lk_dirty}, 32'h0, "flags untouched");
        chk(lk_paddr == {20'h660, 12'hFFF}, "R1", lk_paddr, {20'h660, 12'hFFF}, "max offset");

        // R2: no hit without a request
        @(negedge clk);
        lk_valid = 1'b0;
        #1 chk(lk_hit == 1'b0, "R2", 32'(lk_hit), 32'h0, "idle lookup");

        // R10: reset in mid-run clears the table
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lk_valid = 1'b1; lk_vaddr = {20'h60, 12'h0}; lk_asid = A3;
        #1 chk(lk_hit == 1'b0, "R10", 32'(lk_hit), 32'h0, "after reset");

        @(negedge clk);
        idle();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule